// File: doc/BRIEF.md
# Stereo Silence Flag Detector

This block watches a stereo audio stream and raises a silence flag for each channel, left and right, when that channel carries silent data. It understands three input formats. In PCM mode each sample strobe marks one frame period, and silence means a long unbroken run of all-zero samples. In external-filter mode the same strobe marks one word period, and the run must be eight times longer. In DSD mode each channel is a 1-bit stream, collected into bytes. Silence is then either a byte with as many ones as zeros, or a fixed idle byte that repeats without a break for a set number of time-base ticks.

The control owner supplies the mode, a two-bit DSD test select and a one-bit PCM enable. Each flag is a registered status bit that can be read at any time. Any change to the configuration discards the runs that are in progress. The qualification lengths are parameters, so the full run of 1024 frames and the 200-tick hold can be shortened for simulation.

Top module: `silence_flag_detector`

## Requirements
- R1: While reset is asserted, and at the first edge after it, both flags are low and every run counter is cleared.
- R2: The left and right channels are judged independently. Data on one channel never sets or clears the other channel's flag.
- R3: With mode 00 (PCM) and the enable high, a channel's flag rises at the clock edge that takes the PCM_RUN-th consecutive sample strobe with that channel's data exactly zero. Up to that edge the flag stays low.
- R4: With mode 01 (external filter) and the enable high, the run needed is PCM_RUN*EXT_MULT consecutive zero strobes.
- R5: In PCM or external-filter mode, a strobe with non-zero data on a channel clears that channel's flag at that edge and restarts its run at zero.
- R6: In mode 10 (DSD), each channel's bits are shifted in MSB-first on every DSD bit strobe, and every eighth strobe completes a byte. With select 01, the byte that completes sets the flag when it holds exactly four ones and clears the flag when it does not. Between bytes the flag holds its value.
- R7: In mode 10 with select 1x, the first completed byte equal to 8'h96 arms the channel. After that, every time-base tick counts while each byte that completes stays 8'h96. The flag rises when HOLD_TICKS ticks have been counted. Any other completed byte clears the flag, the count and the arm.
- R8: The detector is disabled when the enable is low in modes 00 and 01, when the select is 00 in mode 10, and at all times in mode 11. While it is disabled, both flags stay low for any data.
- R9: When the mode, the select or the enable differs from its value at the previous edge, both flags clear and all runs restart.
- R10: Once a flag has risen, further qualifying input keeps it high. The counters saturate and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | 00 PCM, 01 external filter, 10 DSD, 11 off |
| dsd_zsel | input | 2 | DSD test: 00 off, 01 balanced byte, 1x idle byte 8'h96 |
| pcm_zen | input | 1 | Enable for PCM and external-filter flags |
| smp_stb | input | 1 | One pulse per frame or word period |
| dsd_stb | input | 1 | One pulse per DSD bit |
| left_smp | input | DATA_W | Left sample |
| right_smp | input | DATA_W | Right sample |
| left_bit | input | 1 | Left DSD bit |
| right_bit | input | 1 | Right DSD bit |
| tick | input | 1 | Time-base tick |
| flag_left | output | 1 | Left silence flag |
| flag_right | output | 1 | Right silence flag |

## Verification
The bench targets the exact edge of each run. It checks the zero strobe just before the limit and the one that reaches it, in both PCM and external-filter mode. An off-by-one counter would raise the flag one strobe early or one strobe late. It also places a single bad byte in a long idle-byte run and a configuration change in the middle of a run. A design that fails to restart the run would then raise the flag too early. Balanced bytes and unbalanced bytes are mixed, with the two channels given different data. A design that shares state between channels, or that evaluates the byte on the wrong strobe, would then set the wrong flag.

// File: rtl/zf_pkg.sv
package zf_pkg;
    typedef enum logic [1:0] {
        MODE_PCM = 2'b00,
        MODE_EXT = 2'b01,
        MODE_DSD = 2'b10,
        MODE_OFF = 2'b11
    } zf_mode_e;

    localparam int          DSD_BYTE_W = 8;
    localparam logic [7:0]  DSD_IDLE   = 8'h96;

    function automatic logic is_balanced(input logic [DSD_BYTE_W-1:0] b);
        return ($countones(b) == DSD_BYTE_W / 2);
    endfunction
endpackage

// File: rtl/zf_cfg_watch.sv
module zf_cfg_watch
    import zf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic [1:0] zsel,
    input  logic       zen,
    output logic       clr
);
    localparam int CFG_W = 5;
    localparam logic [CFG_W-1:0] CFG_RST = {MODE_PCM, 2'b00, 1'b1};

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_now = {mode, zsel, zen};
        cfg_d   = cfg_now;
        clr     = (cfg_now != cfg_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/zf_lane.sv
module zf_lane
    import zf_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int CNT_W      = 14,
    parameter int PCM_RUN    = 1024,
    parameter int EXT_RUN    = 8192,
    parameter int HOLD_TICKS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  zf_mode_e          mode,
    input  logic [1:0]        zsel,
    input  logic              zen,
    input  logic              smp_stb,
    input  logic              dsd_stb,
    input  logic [DATA_W-1:0] smp,
    input  logic              dsd_bit,
    input  logic              tick,
    output logic              flag
);
    localparam logic [CNT_W-1:0] PCM_LIM  = CNT_W'(PCM_RUN);
    localparam logic [CNT_W-1:0] EXT_LIM  = CNT_W'(EXT_RUN);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [DSD_BYTE_W-1:0] sr;
        logic [2:0]            bcnt;
        logic                  armed;
        logic                  flag;
    } lane_t;

    lane_t st_d, st_q;
    logic [DSD_BYTE_W-1:0] byte_nx;
    logic                  byte_done;
    logic                  idle_ok;
    logic [CNT_W-1:0]      lim;

    always_comb begin
        st_d      = st_q;
        byte_nx   = {st_q.sr[DSD_BYTE_W-2:0], dsd_bit};
        byte_done = dsd_stb && (st_q.bcnt == 3'd7);
        idle_ok   = (byte_nx == DSD_IDLE);
        lim       = (mode == MODE_EXT) ? EXT_LIM : PCM_LIM;
        if (clr) begin
            st_d = '0;
        end else begin
            case (mode)
                MODE_PCM, MODE_EXT: begin
                    st_d.sr    = '0;
                    st_d.bcnt  = '0;
                    st_d.armed = 1'b0;
                    if (!zen) begin
                        st_d.cnt  = '0;
                        st_d.flag = 1'b0;
                    end else if (smp_stb) begin
                        if (smp == '0) begin
                            if (st_q.cnt < lim) st_d.cnt = st_q.cnt + 1'b1;
                            st_d.flag = (st_d.cnt >= lim);
                        end else begin
                            st_d.cnt  = '0;
                            st_d.flag = 1'b0;
                        end
                    end
                end
                MODE_DSD: begin
                    if (zsel == 2'b00) begin
                        st_d = '0;
                    end else begin
                        if (dsd_stb) begin
                            st_d.sr   = byte_nx;
                            st_d.bcnt = st_q.bcnt + 3'd1;
                        end
                        if (!zsel[1]) begin
                            st_d.cnt   = '0;
                            st_d.armed = 1'b0;
                            if (byte_done) st_d.flag = is_balanced(byte_nx);
                        end else if (byte_done && !idle_ok) begin
                            st_d.cnt   = '0;
                            st_d.armed = 1'b0;
                            st_d.flag  = 1'b0;
                        end else begin
                            if (tick && st_q.armed && (st_q.cnt < HOLD_LIM))
                                st_d.cnt = st_q.cnt + 1'b1;
                            if (byte_done) st_d.armed = 1'b1;
                            st_d.flag = (st_d.cnt >= HOLD_LIM);
                        end
                    end
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/silence_flag_detector.sv
module silence_flag_detector
    import zf_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int PCM_RUN    = 1024,
    parameter int EXT_MULT   = 8,
    parameter int HOLD_TICKS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        dsd_zsel,
    input  logic              pcm_zen,
    input  logic              smp_stb,
    input  logic              dsd_stb,
    input  logic [DATA_W-1:0] left_smp,
    input  logic [DATA_W-1:0] right_smp,
    input  logic              left_bit,
    input  logic              right_bit,
    input  logic              tick,
    output logic              flag_left,
    output logic              flag_right
);
    localparam int NCH     = 2;
    localparam int EXT_RUN = PCM_RUN * EXT_MULT;
    localparam int CNT_MAX = (EXT_RUN > HOLD_TICKS) ? EXT_RUN : HOLD_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic              clr;
    logic [DATA_W-1:0] smp_a  [NCH];
    logic [NCH-1:0]    bit_a;
    logic [NCH-1:0]    flag_a;

    assign smp_a[0] = left_smp;
    assign smp_a[1] = right_smp;
    assign bit_a    = {right_bit, left_bit};

    zf_cfg_watch u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_sel),
        .zsel  (dsd_zsel),
        .zen   (pcm_zen),
        .clr   (clr)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        zf_lane #(
            .DATA_W     (DATA_W),
            .CNT_W      (CNT_W),
            .PCM_RUN    (PCM_RUN),
            .EXT_RUN    (EXT_RUN),
            .HOLD_TICKS (HOLD_TICKS)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .mode    (zf_mode_e'(mode_sel)),
            .zsel    (dsd_zsel),
            .zen     (pcm_zen),
            .smp_stb (smp_stb),
            .dsd_stb (dsd_stb),
            .smp     (smp_a[ch]),
            .dsd_bit (bit_a[ch]),
            .tick    (tick),
            .flag    (flag_a[ch])
        );
    end

    assign flag_left  = flag_a[0];
    assign flag_right = flag_a[1];
endmodule

// File: rtl/zf_checker.sv
module zf_checker #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic [1:0]        dsd_zsel,
    input logic              pcm_zen,
    input logic              smp_stb,
    input logic              dsd_stb,
    input logic [DATA_W-1:0] left_smp,
    input logic [DATA_W-1:0] right_smp,
    input logic              tick,
    input logic              flag_left,
    input logic              flag_right
);
    logic       pcm_like;
    logic       off_now;
    logic [4:0] cfg;

    assign pcm_like = (mode_sel == 2'b00) || (mode_sel == 2'b01);
    assign off_now  = (pcm_like && !pcm_zen) || (mode_sel == 2'b11) ||
                      ((mode_sel == 2'b10) && (dsd_zsel == 2'b00));
    assign cfg      = {mode_sel, dsd_zsel, pcm_zen};

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!flag_left && !flag_right));

    assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        off_now |=> (!flag_left && !flag_right));

    assert_cfg_change_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (cfg != $past(cfg))) |=> (!flag_left && !flag_right));

    assert_left_nonzero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_like && smp_stb && (left_smp != '0)) |=> !flag_left);

    assert_right_nonzero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_like && smp_stb && (right_smp != '0)) |=> !flag_right);

    assert_rise_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_left) || $rose(flag_right)) |-> $past(smp_stb || dsd_stb || tick));
endmodule

bind silence_flag_detector zf_checker #(.DATA_W(DATA_W)) u_zf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .dsd_zsel   (dsd_zsel),
    .pcm_zen    (pcm_zen),
    .smp_stb    (smp_stb),
    .dsd_stb    (dsd_stb),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .tick       (tick),
    .flag_left  (flag_left),
    .flag_right (flag_right)
);

// File: tb/silence_flag_detector_bench.sv
module silence_flag_detector_bench;
    localparam int DW   = 24;
    localparam int RUN  = 16;
    localparam int MULT = 8;
    localparam int HOLD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] dsd_zsel = 2'b00;
    logic pcm_zen = 1'b1;
    logic smp_stb = 1'b0, dsd_stb = 1'b0, tick = 1'b0;
    logic [DW-1:0] left_smp = '0, right_smp = '0;
    logic left_bit = 1'b0, right_bit = 1'b0;
    logic flag_left, flag_right;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_tag = "";

    always #2 clk = ~clk;

    silence_flag_detector #(.DATA_W(DW), .PCM_RUN(RUN), .EXT_MULT(MULT), .HOLD_TICKS(HOLD))
    u_silence_flag_detector (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dsd_zsel(dsd_zsel),
        .pcm_zen(pcm_zen), .smp_stb(smp_stb), .dsd_stb(dsd_stb),
        .left_smp(left_smp), .right_smp(right_smp), .left_bit(left_bit),
        .right_bit(right_bit), .tick(tick), .flag_left(flag_left), .flag_right(flag_right)
    );

    // Reference model built from the requirements
    int       m_cnt [2];
    bit       m_flag[2];
    bit [7:0] m_sr  [2];
    int       m_bc  [2];
    bit       m_arm [2];
    bit [4:0] m_cfg_prev;

    function automatic string tag_of(bit [4:0] c);
        if (c[4:3] == 2'b11) return "R8";
        if (c[4] == 1'b0) return c[0] ? (c[3] ? "R4" : "R3") : "R8";
        if (c[2:1] == 2'b00) return "R8";
        return c[2] ? "R7" : "R6";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_flag[c] = 0; m_sr[c] = 0; m_bc[c] = 0; m_arm[c] = 0;
            end
            m_cfg_prev = 5'b00001;
        end else begin
            bit [4:0] cfg;
            cfg = {mode_sel, dsd_zsel, pcm_zen};
            for (int c = 0; c < 2; c++) begin
                bit [7:0] b;
                bit d_done;
                bit [DW-1:0] s;
                int lim;
                s = (c == 0) ? left_smp : right_smp;
                b = {m_sr[c][6:0], (c == 0) ? left_bit : right_bit};
                d_done = dsd_stb && (m_bc[c] == 7);
                lim = (mode_sel == 2'b01) ? RUN * MULT : RUN;
                if (cfg != m_cfg_prev || mode_sel == 2'b11 ||
                    (mode_sel == 2'b10 && dsd_zsel == 2'b00)) begin
                    m_cnt[c] = 0; m_flag[c] = 0; m_sr[c] = 0; m_bc[c] = 0; m_arm[c] = 0;
                end else if (mode_sel[1] == 1'b0) begin
                    m_sr[c] = 0; m_bc[c] = 0; m_arm[c] = 0;
                    if (!pcm_zen) begin m_cnt[c] = 0; m_flag[c] = 0; end
                    else if (smp_stb) begin
                        if (s == 0) begin
                            if (m_cnt[c] < lim) m_cnt[c]++;
                            m_flag[c] = (m_cnt[c] >= lim);
                        end else begin m_cnt[c] = 0; m_flag[c] = 0; end
                    end
                end else begin
                    if (dsd_stb) begin m_sr[c] = b; m_bc[c] = (m_bc[c] + 1) % 8; end
                    if (!dsd_zsel[1]) begin
                        m_cnt[c] = 0; m_arm[c] = 0;
                        if (d_done) m_flag[c] = ($countones(b) == 4);
                    end else if (d_done && b != 8'h96) begin
                        m_cnt[c] = 0; m_arm[c] = 0; m_flag[c] = 0;
                    end else begin
                        if (tick && m_arm[c] && m_cnt[c] < HOLD) m_cnt[c]++;
                        if (d_done) m_arm[c] = 1;
                        m_flag[c] = (m_cnt[c] >= HOLD);
                    end
                end
            end
            m_cfg_prev = cfg;
        end
    end

    task automatic expect_bit(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        expect_bit((cur_tag != "") ? cur_tag : tag_of(m_cfg_prev), "flag_left",  flag_left,  m_flag[0]);
        expect_bit((cur_tag != "") ? cur_tag : tag_of(m_cfg_prev), "flag_right", flag_right, m_flag[1]);
    endtask

    task automatic strobes(int n, logic [DW-1:0] l, logic [DW-1:0] r);
        for (int i = 0; i < n; i++) begin
            smp_stb = 1; left_smp = l; right_smp = r; step();
        end
        smp_stb = 0;
    endtask

    task automatic feed_byte(bit [7:0] lb, bit [7:0] rb, bit tick_last);
        for (int i = 7; i >= 0; i--) begin
            dsd_stb = 1; left_bit = lb[i]; right_bit = rb[i];
            tick = tick_last && (i == 0);
            step();
        end
        dsd_stb = 0; tick = 0;
    endtask

    task automatic set_cfg(logic [1:0] m, logic [1:0] z, logic e);
        mode_sel = m; dsd_zsel = z; pcm_zen = e; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 4);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        expect_bit("R1", "flag_left in reset", flag_left, 1'b0);
        expect_bit("R1", "flag_right in reset", flag_right, 1'b0);
        rst_n = 1;
        step();
        expect_bit("R1", "flag_left after reset", flag_left, 1'b0);

        // PCM run boundary, right channel broken midway
        cur_tag = "R3";
        strobes(RUN - 1, '0, '0);
        expect_bit("R3", "left one strobe before limit", flag_left, 1'b0);
        strobes(1, '0, 24'h000100);
        expect_bit("R3", "left at limit", flag_left, 1'b1);
        expect_bit("R2", "right broken by own data", flag_right, 1'b0);
        cur_tag = "R5";
        strobes(1, 24'h800000, '0);
        expect_bit("R5", "nonzero clears left", flag_left, 1'b0);
        cur_tag = "R10";
        strobes(40, '0, '0);
        expect_bit("R10", "left held after long run", flag_left, 1'b1);
        expect_bit("R2", "right reached own limit", flag_right, 1'b1);

        cur_tag = "R9";
        set_cfg(2'b00, 2'b00, 1'b0);
        expect_bit("R9", "enable change clears", flag_left, 1'b0);
        cur_tag = "R8";
        strobes(3 * RUN, '0, '0);
        expect_bit("R8", "PCM disabled", flag_right, 1'b0);

        cur_tag = "R4";
        set_cfg(2'b01, 2'b00, 1'b1);
        strobes(RUN * MULT - 1, '0, '0);
        expect_bit("R4", "ext one before limit", flag_left, 1'b0);
        strobes(1, '0, '0);
        expect_bit("R4", "ext at limit", flag_left, 1'b1);

        cur_tag = "R6";
        set_cfg(2'b10, 2'b01, 1'b1);
        feed_byte(8'h0F, 8'hA5, 0);
        expect_bit("R6", "balanced left", flag_left, 1'b1);
        expect_bit("R6", "balanced right", flag_right, 1'b1);
        feed_byte(8'hFF, 8'h3C, 0);
        expect_bit("R6", "unbalanced left", flag_left, 1'b0);
        expect_bit("R2", "right still balanced", flag_right, 1'b1);

        cur_tag = "R7";
        set_cfg(2'b10, 2'b10, 1'b1);
        for (int k = 0; k < 3; k++) feed_byte(8'h96, 8'h96, 1);
        expect_bit("R7", "idle byte before hold", flag_left, 1'b0);
        for (int k = 0; k < 5; k++) feed_byte(8'h96, 8'h96, 1);
        expect_bit("R7", "idle byte held", flag_left, 1'b1);
        feed_byte(8'h97, 8'h96, 1);
        expect_bit("R7", "bad byte clears", flag_left, 1'b0);
        expect_bit("R2", "right idle intact", flag_right, 1'b1);

        cur_tag = "R8";
        set_cfg(2'b11, 2'b10, 1'b1);
        strobes(2 * RUN, '0, '0);
        for (int k = 0; k < 8; k++) feed_byte(8'h96, 8'h96, 1);
        expect_bit("R8", "mode off", flag_left, 1'b0);

        // Random phases checked against the model every cycle
        cur_tag = "";
        for (int ph = 0; ph < 10; ph++) begin
            mode_sel = 2'($urandom_range(0, 3));
            dsd_zsel = 2'($urandom_range(0, 3));
            pcm_zen  = ($urandom_range(0, 4) != 0);
            for (int n = 0; n < 300; n++) begin
                bit [7:0] lb, rb;
                lb = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h96;
                rb = ($urandom_range(0, 1) == 0) ? lb : 8'($urandom);
                for (int i = 7; i >= 0; i--) begin
                    smp_stb   = ($urandom_range(0, 2) != 0);
                    dsd_stb   = 1;
                    left_bit  = lb[i];
                    right_bit = rb[i];
                    tick      = ($urandom_range(0, 5) == 0);
                    left_smp  = ($urandom_range(0, 60) == 0) ? DW'($urandom) : '0;
                    right_smp = ($urandom_range(0, 30) == 0) ? DW'($urandom) : '0;
                    if ($urandom_range(0, 2000) == 0) pcm_zen = ~pcm_zen; // R9
                    step();
                end
            end
        end
        smp_stb = 0; dsd_stb = 0; tick = 0;
        finish_run();
    end
endmodule